// File: doc/BRIEF.md
# Legacy Memory Attribute and SMRAM Decoder

This block sits in a host bridge and steers every processor memory access either to DRAM or to the PCI bus. Below 1 MB it applies per-region shadow attributes: the 64 KB BIOS area at 0xF0000 and twelve 16 KB expansion segments starting at 0xC0000 each carry a 4-bit attribute nibble. The nibble gives separate read and write permissions toward DRAM. A direction that is not permitted goes to PCI. The 128 KB window at 0xA0000 is governed by an SMRAM control byte. That byte takes two views: accesses made in system management mode use the global enable bit, and all other accesses use the open bit. Above these regions, an address goes to DRAM when it lies below top-of-memory and to PCI otherwise. Top-of-memory is derived from an installed-size input.

Configuration uses a byte-wide port. A write lands in the register file at the clock edge. When the write touches a mapping byte, a two-state machine then reloads the active decode copy. Its states are SYNC_LIVE and SYNC_RELOAD, and it has three transitions:

- **SYNC_LIVE → SYNC_RELOAD** on a mapping write.
- **SYNC_RELOAD → SYNC_RELOAD** on a further mapping write.
- **SYNC_RELOAD → SYNC_LIVE** otherwise.

The decode result is registered, so each response appears one cycle after its access.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset, the seven attribute bytes at offsets 0x59..0x5F read 0x00 and the SMRAM control byte at offset 0x72 reads 0x02.
- R2: Bytes 0x59..0x5F and 0x72 read back the last value written. Any other offset except 0x57 reads 0x00, and writes to it change nothing.
- R3: Offset 0x57 reads the installed size in MB divided by 8 (rounded down) and saturated at 255. Writes to 0x57 have no effect.
- R4: resp_valid is high in the cycle after a cycle with acc_valid high and low otherwise. resp_dram is 1 for DRAM and 0 for PCI.
- R5: Addresses 0xF0000..0xFFFFF use the upper nibble of byte 0x59. Bit 0 of the nibble enables reads to DRAM and bit 1 enables writes to DRAM.
- R6: Segment i (1..12) covers 0xC0000+(i-1)*16 KB. It takes its nibble from byte 0x59+ceil(i/2), using the lower nibble for odd i and the upper nibble for even i, with the same read/write bit meaning as R5.
- R7: A non-SMM access to 0xA0000..0xBFFFF goes to DRAM exactly when bit 6 (open) of byte 0x72 is set.
- R8: An SMM access to 0xA0000..0xBFFFF goes to DRAM exactly when bit 3 (global enable) of byte 0x72 is set, whatever the open bit holds.
- R9: Any other address goes to DRAM when it is below (0x57 value) × 8 MB and to PCI otherwise.
- R10: An access sampled at the same edge as a mapping write, or at the next edge, decodes with the previous mapping. An access sampled two edges after the write uses the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| ram_mb | input | SIZE_W | Installed memory in MB |
| acc_valid | input | 1 | Memory access present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_smm | input | 1 | Access issued in system management mode |
| resp_valid | output | 1 | Decode result valid |
| resp_dram | output | 1 | 1 = DRAM target, 0 = PCI target |

## Verification
A configuration write and a memory access can land on the same clock edge. The bench provokes this by raising cfg_we on byte 0x59 together with acc_valid for the BIOS area, then holding the access for two more edges. The first two responses must follow the old attribute nibble, while the reload state is still pending. The third response must follow the newly written nibble. A checker also requires SYNC_RELOAD to fall back to SYNC_LIVE when no further mapping write arrives.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
    localparam logic [7:0] OFS_TOM   = 8'h57;
    localparam logic [7:0] OFS_PAM   = 8'h59;
    localparam logic [7:0] OFS_SMC   = 8'h72;
    localparam int         PAM_BYTES = 7;
    localparam int         N_REGION  = 13;
    localparam logic [7:0] SMC_RESET = 8'h02;
    localparam int SMC_OPEN_BIT = 6;
    localparam int SMC_EN_BIT   = 3;
    localparam int ATTR_RD_BIT  = 0;
    localparam int ATTR_WR_BIT  = 1;
    localparam int BIOS_BASE = 'hF0000;
    localparam int BIOS_SIZE = 'h10000;
    localparam int SEG_BASE  = 'hC0000;
    localparam int SEG_SIZE  = 'h4000;
    localparam int WIN_BASE  = 'hA0000;
    localparam int WIN_END   = 'hC0000;
    localparam int LOW_END   = 'h100000;
    localparam int TOM_SHIFT = 23;

    typedef enum logic {SYNC_LIVE, SYNC_RELOAD} sync_state_e;

    typedef struct packed {
        logic [PAM_BYTES*8-1:0] pam;
        logic [7:0]             smc;
    } map_cfg_t;
endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs
    import lmd_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [SIZE_W-1:0] ram_mb,
    output logic [7:0]        cfg_rdata,
    output map_cfg_t          live_cfg,
    output logic              map_write,
    output logic [7:0]        tom_units
);
    logic [7:0]        pam_q [PAM_BYTES];
    logic [7:0]        smc_q;
    logic [SIZE_W-1:0] units_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < PAM_BYTES; b++) pam_q[b] <= 8'h00;
            smc_q <= SMC_RESET;
        end else if (cfg_we) begin
            for (int b = 0; b < PAM_BYTES; b++)
                if (cfg_addr == OFS_PAM + 8'(b)) pam_q[b] <= cfg_wdata;
            if (cfg_addr == OFS_SMC) smc_q <= cfg_wdata;
        end
    end

    always_comb begin
        units_full = ram_mb >> 3;
        tom_units  = (units_full > SIZE_W'(255)) ? 8'hFF : units_full[7:0];
    end

    always_comb begin
        map_write = cfg_we &&
                    (((cfg_addr >= OFS_PAM) && (cfg_addr < OFS_PAM + 8'(PAM_BYTES))) ||
                     (cfg_addr == OFS_SMC));
    end

    always_comb begin
        cfg_rdata = 8'h00;
        if (cfg_addr == OFS_TOM) cfg_rdata = tom_units;
        if (cfg_addr == OFS_SMC) cfg_rdata = smc_q;
        for (int b = 0; b < PAM_BYTES; b++)
            if (cfg_addr == OFS_PAM + 8'(b)) cfg_rdata = pam_q[b];
    end

    always_comb begin
        live_cfg.smc = smc_q;
        for (int b = 0; b < PAM_BYTES; b++) live_cfg.pam[b*8 +: 8] = pam_q[b];
    end
endmodule

// File: rtl/lmd_sync_fsm.sv
module lmd_sync_fsm
    import lmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        map_write,
    input  map_cfg_t    live_cfg,
    output map_cfg_t    act_cfg,
    output sync_state_e state_q
);
    sync_state_e state_d;
    logic        load_act;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SYNC_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load_act = 1'b0;
        unique case (state_q)
            SYNC_LIVE: begin
                if (map_write) state_d = SYNC_RELOAD;
            end
            SYNC_RELOAD: begin
                load_act = 1'b1;
                state_d  = map_write ? SYNC_RELOAD : SYNC_LIVE;
            end
            default: state_d = SYNC_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg.pam <= '0;
            act_cfg.smc <= SMC_RESET;
        end else if (load_act) begin
            act_cfg <= live_cfg;
        end
    end
endmodule

// File: rtl/lmd_addr_decode.sv
module lmd_addr_decode
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              is_smm,
    input  map_cfg_t          cfg,
    input  logic [7:0]        tom_units,
    output logic              to_dram
);
    logic [N_REGION-1:0] hit;
    logic [N_REGION-1:0] ok;
    logic                in_win;
    logic [ADDR_W:0]     tom_addr;

    for (genvar r = 0; r < N_REGION; r++) begin : g_region
        localparam logic [ADDR_W-1:0] BASE = (r == 0) ? ADDR_W'(BIOS_BASE)
                                           : ADDR_W'(SEG_BASE + (r - 1) * SEG_SIZE);
        localparam logic [ADDR_W-1:0] SIZE = (r == 0) ? ADDR_W'(BIOS_SIZE) : ADDR_W'(SEG_SIZE);
        localparam int BYTE_IX = (r + 1) / 2;
        localparam int NIB_LSB = BYTE_IX * 8 + (((r % 2) == 0) ? 4 : 0);
        logic [3:0] attr;
        assign attr   = cfg.pam[NIB_LSB +: 4];
        assign hit[r] = (addr >= BASE) && (addr < BASE + SIZE);
        assign ok[r]  = hit[r] & (is_write ? attr[ATTR_WR_BIT] : attr[ATTR_RD_BIT]);
    end

    always_comb begin
        in_win   = (addr >= ADDR_W'(WIN_BASE)) && (addr < ADDR_W'(WIN_END));
        tom_addr = (ADDR_W+1)'(tom_units) << TOM_SHIFT;
        if (in_win)
            to_dram = is_smm ? cfg.smc[SMC_EN_BIT] : cfg.smc[SMC_OPEN_BIT];
        else if (|hit)
            to_dram = |ok;
        else
            to_dram = ({1'b0, addr} < tom_addr);
    end
endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [SIZE_W-1:0] ram_mb,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_smm,
    output logic              resp_valid,
    output logic              resp_dram
);
    map_cfg_t    live_cfg;
    map_cfg_t    act_cfg;
    logic        map_write;
    logic [7:0]  tom_units;
    sync_state_e sync_state;
    logic        dec_dram;

    lmd_cfg_regs #(.SIZE_W(SIZE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ram_mb(ram_mb), .cfg_rdata(cfg_rdata),
        .live_cfg(live_cfg), .map_write(map_write), .tom_units(tom_units)
    );

    lmd_sync_fsm u_sync (
        .clk(clk), .rst_n(rst_n), .map_write(map_write),
        .live_cfg(live_cfg), .act_cfg(act_cfg), .state_q(sync_state)
    );

    lmd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(acc_addr), .is_write(acc_write), .is_smm(acc_smm),
        .cfg(act_cfg), .tom_units(tom_units), .to_dram(dec_dram)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_dram  <= 1'b0;
        end else begin
            resp_valid <= acc_valid;
            resp_dram  <= acc_valid & dec_dram;
        end
    end
endmodule

// File: rtl/legacy_mem_decoder_chk.sv
module legacy_mem_decoder_chk
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_rdata,
    input logic [SIZE_W-1:0] ram_mb,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_smm,
    input logic              resp_valid,
    input logic              resp_dram,
    input logic [7:0]        act_smc,
    input sync_state_e       sync_state
);
    logic [7:0]      exp_units;
    logic [ADDR_W:0] exp_tom;
    logic            high_addr;
    logic            win_addr;
    logic            maps_cfg;

    always_comb begin
        exp_units = ((ram_mb / SIZE_W'(8)) >= SIZE_W'(255)) ? 8'd255 : 8'((ram_mb / SIZE_W'(8)));
        exp_tom   = (ADDR_W+1)'(exp_units) * (ADDR_W+1)'(1 << TOM_SHIFT);
        high_addr = acc_addr >= ADDR_W'(LOW_END);
        win_addr  = (acc_addr >= ADDR_W'(WIN_BASE)) && (acc_addr < ADDR_W'(WIN_END));
        maps_cfg  = cfg_we && ((cfg_addr == OFS_SMC) ||
                    ((cfg_addr >= OFS_PAM) && (cfg_addr <= OFS_PAM + 8'(PAM_BYTES - 1))));
    end

    assert_resp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);
    assert_resp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);
    assert_tom_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == OFS_TOM) |-> (cfg_rdata == exp_units));
    assert_below_tom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && high_addr && ({1'b0, acc_addr} < exp_tom)) |=> resp_dram);
    assert_above_tom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && high_addr && ({1'b0, acc_addr} >= exp_tom)) |=> !resp_dram);
    assert_smm_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_smm && win_addr && !act_smc[SMC_EN_BIT]) |=> !resp_dram);
    assert_reload_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_state == SYNC_RELOAD && !maps_cfg) |=> (sync_state == SYNC_LIVE));
endmodule

bind legacy_mem_decoder legacy_mem_decoder_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_rdata(cfg_rdata), .ram_mb(ram_mb), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_smm(acc_smm), .resp_valid(resp_valid),
    .resp_dram(resp_dram), .act_smc(act_cfg.smc), .sync_state(sync_state)
);

// File: tb/legacy_mem_decoder_tb.sv
module legacy_mem_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] ram_mb = 16'd64;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_smm = 1'b0;
    logic        resp_valid;
    logic        resp_dram;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    legacy_mem_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ram_mb(ram_mb),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_smm(acc_smm), .resp_valid(resp_valid), .resp_dram(resp_dram)
    );

    // {addr, write, smm, expected dram}; config 59=10 5A=21 5F=03 72=0A, 64 MB
    localparam logic [34:0] VEC [16] = '{
        {32'h000F0000, 1'b0, 1'b0, 1'b1},  // R5 read on
        {32'h000FFFFF, 1'b1, 1'b0, 1'b0},  // R5 write off
        {32'h000C0000, 1'b0, 1'b0, 1'b1},  // R6 seg1 lower nibble read
        {32'h000C3FFF, 1'b1, 1'b0, 1'b0},  // R6 seg1 write off
        {32'h000C4000, 1'b0, 1'b0, 1'b0},  // R6 seg2 upper nibble read off
        {32'h000C7FFF, 1'b1, 1'b0, 1'b1},  // R6 seg2 write on
        {32'h000E8000, 1'b1, 1'b0, 1'b1},  // R6 seg11 lower of 5F
        {32'h000EC000, 1'b0, 1'b0, 1'b0},  // R6 seg12 upper of 5F
        {32'h000C8000, 1'b0, 1'b0, 1'b0},  // R6 seg3 byte 5B zero
        {32'h000A0000, 1'b0, 1'b0, 1'b0},  // R7 closed
        {32'h000BFFFF, 1'b0, 1'b1, 1'b1},  // R8 enabled
        {32'h0009FFFF, 1'b0, 1'b0, 1'b1},  // R9 low DRAM
        {32'h00100000, 1'b1, 1'b0, 1'b1},  // R9
        {32'h03FFFFFF, 1'b0, 1'b0, 1'b1},  // R9 last below TOM
        {32'h04000000, 1'b0, 1'b0, 1'b0},  // R9 at TOM
        {32'hFFFF0000, 1'b0, 1'b1, 1'b0}   // R9 high
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic access(input logic [31:0] a, input logic w, input logic s,
                          output logic v, output logic dr);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_smm = s;
        @(posedge clk);
        #1 v = resp_valid; dr = resp_dram;
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic v, dr;
        repeat (3) @(posedge clk);
        #1 check("R4 reset resp_valid", 32'(resp_valid), 0);
        rst_n = 1'b1;

        for (int b = 0; b < 7; b++) begin
            cfg_read(8'h59 + 8'(b), rd);
            check("R1 attribute reset", 32'(rd), 0);
        end
        cfg_read(8'h72, rd); check("R1 smram reset", 32'(rd), 32'h02);
        cfg_read(8'h57, rd); check("R3 size 64MB", 32'(rd), 8);
        access(32'h000F0000, 1'b0, 1'b0, v, dr);
        check("R4 valid", 32'(v), 1);
        check("R5 reset attr to PCI", 32'(dr), 0);

        cfg_write(8'h59, 8'h10);
        cfg_write(8'h5A, 8'h21);
        cfg_write(8'h5F, 8'h03);
        cfg_write(8'h72, 8'h0A);
        cfg_read(8'h59, rd); check("R2 readback 59", 32'(rd), 32'h10);
        cfg_read(8'h5A, rd); check("R2 readback 5A", 32'(rd), 32'h21);
        cfg_read(8'h72, rd); check("R2 readback 72", 32'(rd), 32'h0A);

        for (int i = 0; i < 16; i++) begin
            access(VEC[i][34:3], VEC[i][2], VEC[i][1], v, dr);
            check($sformatf("R5/R6/R7/R8/R9 vector %0d", i), 32'(dr), 32'(VEC[i][0]));
        end

        cfg_write(8'h60, 8'hAA);
        cfg_read(8'h60, rd); check("R2 unmapped reads zero", 32'(rd), 0);
        cfg_read(8'h5F, rd); check("R2 neighbour intact", 32'(rd), 32'h03);

        cfg_write(8'h57, 8'h11);
        cfg_read(8'h57, rd); check("R3 write ignored", 32'(rd), 8);
        ram_mb = 16'd4000;
        cfg_read(8'h57, rd); check("R3 saturate", 32'(rd), 32'hFF);
        access(32'h7F7FFFFF, 1'b0, 1'b0, v, dr); check("R9 below saturated TOM", 32'(dr), 1);
        access(32'h7F800000, 1'b0, 1'b0, v, dr); check("R9 at saturated TOM", 32'(dr), 0);
        ram_mb = 16'd7;
        cfg_read(8'h57, rd); check("R3 rounds down", 32'(rd), 0);
        access(32'h00000000, 1'b0, 1'b0, v, dr); check("R9 zero TOM", 32'(dr), 0);
        ram_mb = 16'd64;

        cfg_write(8'h72, 8'h42);
        access(32'h000A0000, 1'b0, 1'b0, v, dr); check("R7 open", 32'(dr), 1);
        access(32'h000B0000, 1'b1, 1'b1, v, dr); check("R8 disabled despite open", 32'(dr), 0);

        // R10: write 59 to 00 together with a BIOS read
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h59; cfg_wdata = 8'h00;
        acc_valid = 1'b1; acc_addr = 32'h000F0000; acc_write = 1'b0; acc_smm = 1'b0;
        @(posedge clk);
        #1 check("R10 same edge old map", 32'(resp_dram), 1);
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk);
        #1 check("R10 reload edge old map", 32'(resp_dram), 1);
        @(posedge clk);
        #1 check("R10 new map", 32'(resp_dram), 0);
        acc_valid = 1'b0;
        @(posedge clk);
        #1 check("R4 idle", 32'(resp_valid), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule